// File: doc/BRIEF.md
# Word-wide link data scrambler keystream

This block supplies the keystream for a link-layer scrambler. A 16-bit Galois-style linear-feedback register holds the scrambling state. A chain of single-bit advance stages, unrolled in combinational logic, derives a full data word of pseudo-random bits from that state. On each enabled clock the state jumps forward by as many bit-steps as the word holds, so a fresh word is ready every cycle with no stall.

A companion datapath XORs the word with payload data. Running the same keystream on the receive side restores the data. This block holds no state other than the context. It does not handle primitives, masking or framing.

Top module: `scr_keystream`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the context is loaded with the seed (default 0xF0F6). After reset is released, `key_o` is the word generated from that seed.
- R2: Bit 0 of `key_o` comes from the earliest bit-step and bit i from the i-th step. The bit emitted by a step is context bit 15, taken before the step is applied.
- R3: One bit-step shifts the context left by one and fills bit 0 with zero. If the bit shifted out (old bit 15) was 1, the result is XORed with 0xA011, which is the polynomial x^16+x^15+x^13+x^4+1.
- R4: On a rising edge with `rst_n` high and `ce` high, the context advances by WORD_W bit-steps. `key_o` then shows the word generated from the new context.
- R5: On a rising edge with `rst_n` high and `ce` low, the context and `key_o` do not change.
- R6: Reset takes priority over `ce`. A low `rst_n` reloads the seed even when `ce` is high.
- R7: Over a long run of enabled cycles, the sequence of words matches a bit-serial software model word for word.
- R8: The context never becomes all-zero. When WORD_W is at least 16, `key_o` is never zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset that reloads the seed |
| ce | input | 1 | Clock enable that advances the context by one word |
| key_o | output | WORD_W | Current scrambling word, combinational from the context |

## Verification
The bench builds two instances. The first uses the defaults: a 32-bit word and seed 0xF0F6. It covers the full-width jump of 32 steps, with 16 of those steps reaching past the context width. The second uses an 8-bit word and seed 0x0001. With a sparse seed the feedback taps stay idle for several steps before the first one fires. The shorter jump also shows that the step count is not tied to a fixed width of 32. Both instances run the same table of reset and enable patterns, and the default instance then runs a long enabled stretch.

// File: rtl/scr_pkg.sv
// Shared definitions for the keystream scrambler.
// Assumes a 16-bit feedback context; the word width is set per instance.
package scr_pkg;
    localparam int unsigned CTX_W = 16;
    localparam int unsigned CTX_MSB = CTX_W - 1;
    typedef logic [CTX_W-1:0] ctx_t;
endpackage

// File: rtl/scr_bit_step.sv
// One Galois bit-step of the feedback register.
// Emits the current top bit, shifts left, and folds the taps in when that bit is 1.
// Assumes POLY holds the polynomial without its x^CTX_W term.
module scr_bit_step
    import scr_pkg::*;
#(
    parameter ctx_t POLY = 16'hA011
) (
    input  ctx_t st_i,
    output ctx_t st_o,
    output logic bit_o
);
    // Purpose: produce the output bit and the state after one step.
    always_comb begin
        bit_o = st_i[CTX_MSB];
        st_o  = {st_i[CTX_MSB-1:0], 1'b0} ^ (st_i[CTX_MSB] ? POLY : '0);
    end
endmodule

// File: rtl/scr_advance.sv
// Unrolled chain of WORD_W bit-steps.
// Bit i of the word comes from step i, so bit 0 is the earliest.
// The state after the last step is the next context.
// Assumes WORD_W >= 1; the logic depth grows linearly with WORD_W.
module scr_advance
    import scr_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter ctx_t        POLY   = 16'hA011
) (
    input  ctx_t              ctx_i,
    output logic [WORD_W-1:0] word_o,
    output ctx_t              ctx_o
);
    ctx_t chain [WORD_W+1];

    assign chain[0] = ctx_i;

    for (genvar g = 0; g < WORD_W; g++) begin : g_step
        scr_bit_step #(.POLY(POLY)) u_step (
            .st_i  (chain[g]),
            .st_o  (chain[g+1]),
            .bit_o (word_o[g])
        );
    end

    assign ctx_o = chain[WORD_W];
endmodule

// File: rtl/scr_ctx_reg.sv
// Context register for the keystream scrambler.
// Synchronous active-low reset loads SEED and takes priority over ce.
// Assumes SEED is nonzero; otherwise the sequence sticks at zero.
module scr_ctx_reg
    import scr_pkg::*;
#(
    parameter ctx_t SEED = 16'hF0F6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  ctx_t nxt_i,
    output ctx_t ctx_o
);
    // Purpose: hold the context; reload the seed on reset, advance when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctx_o <= SEED;
        else if (ce)
            ctx_o <= nxt_i;
    end

    // R5: with ce low the context is held.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(ctx_o));

    // R4: an enabled edge takes the state computed by the advance chain.
    a_r4_advance: assert property (@(posedge clk) disable iff (!rst_n)
        ce |=> (ctx_o == $past(nxt_i)));

    // R8: the context never collapses to zero.
    a_r8_ctx_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_o != '0);
endmodule

// File: rtl/scr_keystream.sv
// Top of the word-wide scrambler keystream generator.
// Presents WORD_W keystream bits each cycle, computed combinationally
// from a 16-bit registered context. ce advances the context by WORD_W steps.
// Assumes the payload XOR is done outside this block.
module scr_keystream
    import scr_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter ctx_t        POLY   = 16'hA011,
    parameter ctx_t        SEED   = 16'hF0F6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    output logic [WORD_W-1:0] key_o
);
    ctx_t ctx_q;
    ctx_t ctx_nxt;

    scr_advance #(.WORD_W(WORD_W), .POLY(POLY)) u_adv (
        .ctx_i  (ctx_q),
        .word_o (key_o),
        .ctx_o  (ctx_nxt)
    );

    scr_ctx_reg #(.SEED(SEED)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .ce    (ce),
        .nxt_i (ctx_nxt),
        .ctx_o (ctx_q)
    );

    // R2: the lowest word bit is the top context bit before any step.
    a_r2_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
        key_o[0] == ctx_q[CTX_MSB]);

    // R1: the edge after a reset edge shows the word of the seed state.
    a_r1_seed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ctx_q == SEED));

    // R8: with at least CTX_W bits per word, a nonzero state never gives a zero word.
    if (WORD_W >= CTX_W) begin : g_nz
        a_r8_key_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
            key_o != '0);
    end
endmodule

// File: tb/tb_scr_keystream.sv
module tb_scr_keystream;
    localparam logic [15:0] TAPS  = 16'hA011;
    localparam logic [15:0] SEED0 = 16'hF0F6;
    localparam logic [15:0] SEED1 = 16'h0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce = 1'b0;
    logic [31:0] key0;
    logic [7:0]  key1;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    logic [15:0] m0, m1;

    always #10 clk = ~clk;

    scr_keystream dut (
        .clk (clk), .rst_n (rst_n), .ce (ce), .key_o (key0)
    );

    scr_keystream #(.WORD_W(8), .SEED(SEED1)) dut_b (
        .clk (clk), .rst_n (rst_n), .ce (ce), .key_o (key1)
    );

    // Bit-serial reference: one step per loop pass.
    function automatic logic [31:0] ref_word(logic [15:0] s, int n);
        logic [31:0] w = '0;
        for (int i = 0; i < n; i++) begin
            w[i] = s[15];
            s = {s[14:0], 1'b0} ^ (s[15] ? TAPS : 16'h0);
        end
        return w;
    endfunction

    function automatic logic [15:0] ref_next(logic [15:0] s, int n);
        for (int i = 0; i < n; i++)
            s = {s[14:0], 1'b0} ^ (s[15] ? TAPS : 16'h0);
        return s;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply inputs at a falling edge, update the models at the rising
    // edge, then compare both instances at the next falling edge.
    task automatic cycle(logic r, logic c, string req);
        rst_n = r;
        ce = c;
        @(posedge clk);
        if (!r) begin
            m0 = SEED0;
            m1 = SEED1;
        end else if (c) begin
            m0 = ref_next(m0, 32);
            m1 = ref_next(m1, 8);
        end
        @(negedge clk);
        check(req, key0, ref_word(m0, 32));
        check(req, {24'h0, key1}, {24'h0, ref_word(m1, 8)});
    endtask

    // Stimulus table: {rst_n, ce} per cycle.
    localparam logic [1:0] STIM [24] = '{
        2'b00, 2'b11, 2'b11, 2'b10, 2'b10, 2'b11, 2'b11, 2'b11,
        2'b01, 2'b11, 2'b10, 2'b11, 2'b10, 2'b10, 2'b10, 2'b11,
        2'b11, 2'b00, 2'b10, 2'b11, 2'b11, 2'b11, 2'b10, 2'b11
    };

    initial begin
        #(20 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        m0 = SEED0;
        m1 = SEED1;
        @(negedge clk);
        // R1: reset state, and reset held for two edges.
        cycle(1'b0, 1'b0, "R1");
        cycle(1'b0, 1'b0, "R1");

        // R2 and R3: a hand-derived step from seed 0x0001 on the 8-bit instance.
        // Eight steps shift the single 1 up to bit 8; no tap fires, so the word is 0.
        check("R2", {24'h0, key1}, 32'h0);
        check("R3", {16'h0, ref_next(16'h8000, 1)}, {16'h0, TAPS});

        // R4, R5 and R6 driven from the table.
        foreach (STIM[i]) begin
            if (!STIM[i][1])     cycle(STIM[i][1], STIM[i][0], "R6");
            else if (STIM[i][0]) cycle(STIM[i][1], STIM[i][0], "R4");
            else                 cycle(STIM[i][1], STIM[i][0], "R5");
        end

        // R5: a long hold keeps the word steady.
        for (int i = 0; i < 5; i++) cycle(1'b1, 1'b0, "R5");

        // R6: reset with ce high returns to the seed words.
        cycle(1'b0, 1'b1, "R6");
        check("R6", key0, ref_word(SEED0, 32));

        // R7 and R8: long enabled run.
        for (int i = 0; i < 1000; i++) begin
            cycle(1'b1, 1'b1, "R7");
            n_chk++;
            if (key0 == 32'h0) begin
                n_bad++;
                $display("FAIL R8 actual=%h expected=nonzero", key0);
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule